// File: doc/BRIEF.md
# Serial-In Latched Sink Driver Control Logic

This block is the digital control path of a cascadable sixteen-channel LED sink driver. A host moves a channel pattern in one bit at a time: a serial data bit is taken into the first stage of a shift register when the shift clock rises, and every later rising edge moves the stored bits one stage onward. The final stage is brought out as a serial output, so that the serial input of a second device can be fed from it and a long chain of devices can be loaded from one data line.

A bank of latches sits behind the shift register. While latch-enable is high, the bank follows the register. When latch-enable goes low, the bank holds the last pattern, so the host can shift in the next frame while the present one stays on show. An active-low output-enable blanks all channels at once without disturbing the latched pattern. The outputs are logic-level "sink on" requests, one per channel. A 1 turns the channel on.

The shift clock, the serial data and latch-enable are sampled by the block's own system clock through synchronizer chains. Output-enable gates the channels combinationally. The serial interface is edge-sampled and carries no valid/ready handshake, so it has no back-pressure. The host must keep each shift-clock level for at least SYNC_STAGES+1 system cycles. It must hold serial data steady from one system cycle before each shift-clock rise until one system cycle after it. If the latches are left open while data is shifted, output-enable must be held high during the shifting, so that the moving bits do not reach the outputs.

Top module: `sink_drv_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every shift stage and every latch, so all channel outputs and the serial output read 0 after reset.
- R2: A rising shift clock moves each stage up by one and loads the serial input bit into stage 0. Data changes while the shift clock is steady, and the falling edge of the shift clock, leave the register unchanged.
- R3: Bit order is MSB-first toward channel 15. After a 16-bit word W is shifted with its bit 15 first and then latched, channel output c equals bit c of W.
- R4: The serial output always shows stage 15. After k further shifts of a loaded word W, it shows bit 15-k of W, which is what a cascaded second device needs.
- R5: While the synchronized latch-enable is high, the latch bank takes the shift register contents on every system clock, so the channels follow each shift.
- R6: While latch-enable is low, the latch bank holds its value whatever is shifted in.
- R7: With output-enable high, all 16 channel outputs are 0. The latched data is kept, and when output-enable returns low each channel again shows its latch, including data latched while the outputs were blanked.
- R8: Output-enable acts on the channel outputs combinationally, with no system clock edge needed.
- R9: With SYNC_STAGES=2, consider a shift-clock rise first sampled at system edge k. Stage 0 changes at edge k+2. With latch-enable held high, the channel outputs show the change at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi_i | input | 1 | Serial data input |
| sclk_i | input | 1 | Shift clock; a rising level change shifts the register |
| le_i | input | 1 | Latch-enable; while high, the latches follow the register |
| oe_n_i | input | 1 | Active-low output-enable; high blanks all channels |
| sdo_o | output | 1 | Serial data output (stage 15) for cascading |
| chan_on_o | output | CHANNELS | Per-channel sink-on request, 1 = on |

## Verification
The bench builds the block with its default values: CHANNELS=16 and SYNC_STAGES=2. These values bring a whole 16-bit word, its bit order and its run-out through the serial output within reach. They also let the bench check the exact three-edge lag from a shift-clock rise to a visible channel change. With latches held open and with latches closed, the bench checks the channel outputs against an independent behavioural model on every clock, in addition to directed checks of blanking while new data is latched and of a reset in mid-run.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned CHANNELS_DEF = 16;
  localparam int unsigned SYNC_DEF     = 2;
  localparam int unsigned LANES        = 3;
  localparam int unsigned LANE_DATA    = 0;
  localparam int unsigned LANE_SCLK    = 1;
  localparam int unsigned LANE_LE      = 2;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[LAST];
endmodule

// File: rtl/sld_rise.sv
module sld_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sld_shifter.sv
module sld_shifter #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [N-1:0] sr_q
);
  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[N-2:0], bit_i};
  end
endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/sld_blank.sv
module sld_blank #(
  parameter int unsigned N = 16
) (
  input  logic         blank_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar c = 0; c < N; c++) begin : g_chan
    assign q_o[c] = d_i[c] & ~blank_i;
  end
endmodule

// File: rtl/sink_drv_ctrl.sv
module sink_drv_ctrl
  import sld_pkg::*;
#(
  parameter int unsigned CHANNELS    = CHANNELS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sdi_i,
  input  logic                sclk_i,
  input  logic                le_i,
  input  logic                oe_n_i,
  output logic                sdo_o,
  output logic [CHANNELS-1:0] chan_on_o
);
  localparam int unsigned TOP = CHANNELS - 1;

  logic [LANES-1:0]    raw_in;
  logic [LANES-1:0]    sync_q;
  logic                data_s;
  logic                sclk_s;
  logic                le_s;
  logic                shift_rise;
  logic [CHANNELS-1:0] shreg_q;
  logic [CHANNELS-1:0] latch_q;

  always_comb begin
    raw_in            = '0;
    raw_in[LANE_DATA] = sdi_i;
    raw_in[LANE_SCLK] = sclk_i;
    raw_in[LANE_LE]   = le_i;
  end

  sld_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (sync_q)
  );

  assign data_s = sync_q[LANE_DATA];
  assign sclk_s = sync_q[LANE_SCLK];
  assign le_s   = sync_q[LANE_LE];

  sld_rise u_rise (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (sclk_s),
    .rise_o (shift_rise)
  );

  sld_shifter #(.N(CHANNELS)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_i (shift_rise),
    .bit_i   (data_s),
    .sr_q    (shreg_q)
  );

  sld_latch_bank #(.N(CHANNELS)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .load_i (le_s),
    .d_i    (shreg_q),
    .q_o    (latch_q)
  );

  sld_blank #(.N(CHANNELS)) u_blank (
    .blank_i (oe_n_i),
    .d_i     (latch_q),
    .q_o     (chan_on_o)
  );

  assign sdo_o = shreg_q[TOP];
endmodule

// File: rtl/sink_drv_ctrl_chk.sv
module sink_drv_ctrl_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         oe_n_i,
  input logic         le_s,
  input logic         data_s,
  input logic         shift_rise,
  input logic [N-1:0] shreg_q,
  input logic [N-1:0] latch_q,
  input logic [N-1:0] chan_on_o,
  input logic         sdo_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (shreg_q == '0 && latch_q == '0 && sdo_o == 1'b0));

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
    shift_rise |=> shreg_q == {$past(shreg_q[N-2:0]), $past(data_s)});

  assert_no_shift_R2: assert property (@(posedge clk) disable iff (rst)
    !shift_rise |=> $stable(shreg_q));

  assert_sdo_steady_R4: assert property (@(posedge clk) disable iff (rst)
    !shift_rise |=> $stable(sdo_o));

  assert_follow_R5: assert property (@(posedge clk) disable iff (rst)
    le_s |=> latch_q == $past(shreg_q));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !le_s |=> $stable(latch_q));

  assert_blank_R7: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> chan_on_o == '0);

  assert_restore_R7: assert property (@(posedge clk) disable iff (rst)
    !oe_n_i |-> chan_on_o == latch_q);
endmodule

bind sink_drv_ctrl sink_drv_ctrl_chk #(.N(CHANNELS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .oe_n_i     (oe_n_i),
  .le_s       (le_s),
  .data_s     (data_s),
  .shift_rise (shift_rise),
  .shreg_q    (shreg_q),
  .latch_q    (latch_q),
  .chan_on_o  (chan_on_o),
  .sdo_o      (sdo_o)
);

// File: tb/sink_drv_ctrl_bench.sv
`timescale 1ns/1ps
module sink_drv_ctrl_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi = 1'b0;
  logic sclk = 1'b0;
  logic le = 1'b0;
  logic oe_n = 1'b0;
  logic sdo;
  logic [N-1:0] chan;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sink_drv_ctrl #(.CHANNELS(N), .SYNC_STAGES(2)) u_sink_drv_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sdi_i     (sdi),
    .sclk_i    (sclk),
    .le_i      (le),
    .oe_n_i    (oe_n),
    .sdo_o     (sdo),
    .chan_on_o (chan)
  );

  // Behavioural reference: input histories in queues (index 0 = newest sample)
  logic [N-1:0] m_sr = '0;
  logic [N-1:0] m_lat = '0;
  bit q_clk[$] = '{0, 0, 0, 0};
  bit q_din[$] = '{0, 0, 0, 0};
  bit q_le[$]  = '{0, 0, 0, 0};

  task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [N-1:0] old_sr;
    if (rst) begin
      m_sr = '0;
      m_lat = '0;
      q_clk = '{0, 0, 0, 0};
      q_din = '{0, 0, 0, 0};
      q_le  = '{0, 0, 0, 0};
    end else begin
      q_clk.push_front(sclk); void'(q_clk.pop_back());
      q_din.push_front(sdi);  void'(q_din.pop_back());
      q_le.push_front(le);    void'(q_le.pop_back());
      old_sr = m_sr;
      if (q_clk[2] && !q_clk[3]) m_sr = {m_sr[N-2:0], q_din[2]};
      if (q_le[2]) m_lat = old_sr;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R5/R7", "model chan", chan, oe_n ? '0 : m_lat);
    chk("R4", "model sdo", {{(N-1){1'b0}}, sdo}, {{(N-1){1'b0}}, m_sr[N-1]});
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic shift_bit(logic b);
    sdi = b;
    ticks(2);
    sclk = 1'b1;
    ticks(3);
    sclk = 1'b0;
    ticks(2);
  endtask

  task automatic shift_word(logic [N-1:0] w);
    for (int i = N - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_le();
    le = 1'b1;
    ticks(4);
    le = 1'b0;
    ticks(4);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual no end after 100000 cycles, expected end before");
    summary();
    $finish;
  end

  initial begin
    logic [N-1:0] w;
    @(negedge clk);
    ticks(4);
    chk("R1", "chan after reset", chan, '0);
    chk("R1", "sdo after reset", {{(N-1){1'b0}}, sdo}, '0);
    rst = 1'b0;
    ticks(3);

    // R2: one rising edge loads stage 0
    shift_bit(1'b1);
    pulse_le();
    chk("R2", "one shift", chan, 16'h0001);
    // R2: data toggling with steady shift clock does nothing
    for (int i = 0; i < 6; i++) begin
      sdi = ~sdi;
      ticks(3);
    end
    pulse_le();
    chk("R2", "no edge no shift", chan, 16'h0001);

    // R6 and R3: shift a word with latches closed, then latch
    w = 16'hA5C3;
    shift_word(w);
    chk("R6", "latch held during shift", chan, 16'h0001);
    chk("R4", "sdo shows stage 15", {{(N-1){1'b0}}, sdo}, {{(N-1){1'b0}}, w[15]});
    pulse_le();
    chk("R3", "word order", chan, w);

    // R4: run the word out through the serial output
    for (int k = 0; k < N; k++) begin
      chk("R4", "sdo run-out", {{(N-1){1'b0}}, sdo}, {{(N-1){1'b0}}, w[N-1-k]});
      shift_bit(1'b0);
    end
    chk("R6", "latch kept during run-out", chan, w);

    // R7 and R8: blanking
    shift_word(16'hFFFF);
    pulse_le();
    chk("R7", "all on", chan, 16'hFFFF);
    oe_n = 1'b1;
    #1;
    chk("R8", "blank without clock", chan, '0);
    @(negedge clk);
    shift_word(16'h1234);
    pulse_le();
    chk("R7", "blanked while latching", chan, '0);
    oe_n = 1'b0;
    #1;
    chk("R8", "unblank without clock", chan, 16'h1234);
    @(negedge clk);
    tick();
    chk("R7", "restored latch", chan, 16'h1234);

    // R5: latches open, channels follow shifts
    shift_word(16'h0000);
    pulse_le();
    le = 1'b1;
    ticks(4);
    shift_bit(1'b1);
    chk("R5", "follow 1", chan, 16'h0001);
    shift_bit(1'b1);
    chk("R5", "follow 2", chan, 16'h0003);
    shift_bit(1'b0);
    chk("R5", "follow 3", chan, 16'h0006);

    // R9: exact lag from shift clock rise to channel change
    sdi = 1'b1;
    ticks(2);
    sclk = 1'b1;
    tick();
    chk("R9", "edge k", chan, 16'h0006);
    tick();
    chk("R9", "edge k+1", chan, 16'h0006);
    tick();
    chk("R9", "edge k+2", chan, 16'h0006);
    tick();
    chk("R9", "edge k+3", chan, 16'h000D);
    sclk = 1'b0;
    ticks(3);

    // R7: latches bypassed, outputs held blank during shifting
    oe_n = 1'b1;
    shift_word(16'h5A0F);
    chk("R7", "bypass blanked", chan, '0);
    oe_n = 1'b0;
    tick();
    chk("R7", "bypass shown", chan, 16'h5A0F);

    // R1: reset in mid-run
    rst = 1'b1;
    ticks(2);
    chk("R1", "mid-run reset chan", chan, '0);
    chk("R1", "mid-run reset sdo", {{(N-1){1'b0}}, sdo}, '0);
    rst = 1'b0;
    le = 1'b0;
    ticks(4);
    chk("R1", "stays clear", chan, '0);

    summary();
    $finish;
  end
endmodule